// File: doc/BRIEF.md
# Per-Line Interrupt Trigger Conditioner

This block sits between sixteen raw interrupt request pins and a downstream interrupt controller. For each line it applies one of two modes. In edge mode the line is active high and a rising edge is held as a pending request. In level mode the line is active low and its inverted level passes straight through, so several open-drain sources can share one wire. The mode is chosen per line by a bit in one of two byte-wide registers reached through I/O reads and writes.

The two registers sit at consecutive I/O addresses. The lower address covers lines 0 to 7 and the upper address covers lines 8 to 15. Five lines are reserved for system use: the timer, keyboard, cascade, clock-alarm and coprocessor lines. These lines are hard-wired to edge mode. Raw inputs are asynchronous and pass through a two-flop synchronizer before any mode logic sees them. A pending edge request stays set until the downstream controller pulses the acknowledge input for that line.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset both mode registers read 0x00, every line is in edge mode, and with all raw inputs low every request output is low.
- R2: A write to BASE_ADDR (default 0x04D0) loads mode bits for lines 0-7, and bit n maps to line n. A write to BASE_ADDR+1 loads lines 8-15, and bit n maps to line 8+n. A read at either address returns that register. Writes to any other address change nothing. io_rdata_o is 0x00 whenever no read hits a register.
- R3: The fixed lines 0, 1, 2, 8 and 13 always read as 0 and ignore writes of 1. This is bit 0, 1 and 2 of the lower register and bit 0 and 5 of the upper register.
- R4: A line with mode bit 0 is in edge mode. There a 0-to-1 change of the raw input sets the request output high 3 clock edges after the input change is sampled. The output then stays high after the input returns low.
- R5: In edge mode, a one-cycle pulse on irq_ack_i for that line clears its request at the next edge. If a new rising edge is detected in the same cycle as the acknowledge, the request stays set.
- R6: A line with mode bit 1 is in level mode. There the request output equals the inverted raw input, delayed by 2 clock edges, with no latching.
- R7: A write that changes a line's mode bit clears that line's pending edge request. When the line returns to edge mode, no stale request appears.
- R8: A fixed line keeps edge behaviour even after a write of all ones to its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O address |
| io_wr_i | input | 1 | I/O write strobe, one cycle |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, combinational |
| irq_raw_i | input | N_LINES | Asynchronous raw request inputs |
| irq_ack_i | input | N_LINES | Per-line acknowledge pulses |
| irq_req_o | output | N_LINES | Conditioned requests to the interrupt controller |

## Verification
The bench samples the edge-mode request one edge before and at the expected latency. A missing or extra synchronizer stage therefore shows up as a miscompare. It drives a fresh rising edge in the same cycle as an acknowledge; a design that let the acknowledge win would drop that interrupt. It sets a pending request, then moves the line to level mode and back while the input stays high. A design that kept the stale flag would raise a request nobody sent. It also writes all ones to both registers and to a neighbouring address. This catches reserved bits that stick, fixed lines that change mode, and a loose address decode.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int unsigned REG_W         = 8;
  localparam int unsigned DEF_LINES     = 16;
  localparam int unsigned DEF_ADDR_W    = 16;
  localparam logic [15:0] DEF_BASE_ADDR = 16'h04D0;
  localparam logic [15:0] DEF_FIXED     = 16'h2107; // lines 0,1,2,8,13
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/trig_mode_regs.sv
module trig_mode_regs import irq_trig_pkg::*; #(
  parameter int unsigned         ADDR_W     = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]   BASE_ADDR  = DEF_BASE_ADDR,
  parameter int unsigned         N_LINES    = DEF_LINES,
  parameter logic [N_LINES-1:0]  FIXED_MASK = DEF_FIXED
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  io_addr_i,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  input  logic [REG_W-1:0]   io_wdata_i,
  output logic [REG_W-1:0]   io_rdata_o,
  output logic [N_LINES-1:0] mode_o,
  output logic [N_LINES-1:0] mode_chg_o
);
  localparam int unsigned N_REGS = N_LINES / REG_W;

  logic [N_LINES-1:0] mode_q, mode_d;
  logic [N_REGS-1:0]  addr_hit;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    assign addr_hit[r] = (io_addr_i == BASE_ADDR + ADDR_W'(r));
    assign mode_d[r*REG_W +: REG_W] =
      (io_wr_i && addr_hit[r]) ? (io_wdata_i & ~FIXED_MASK[r*REG_W +: REG_W])
                               : mode_q[r*REG_W +: REG_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_d;
  end

  always_comb begin
    io_rdata_o = '0;
    for (int r = 0; r < N_REGS; r++)
      if (io_rd_i && addr_hit[r]) io_rdata_o = mode_q[r*REG_W +: REG_W];
  end

  assign mode_o     = mode_q;
  assign mode_chg_o = mode_d ^ mode_q;
endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic level_mode_i,
  input  logic mode_chg_i,
  input  logic ack_i,
  output logic req_o
);
  logic prev_q, pend_q, rise;

  assign rise = sync_i & ~prev_q & ~level_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (mode_chg_i)  pend_q <= 1'b0;
      else if (rise)   pend_q <= 1'b1; // new edge beats ack
      else if (ack_i)  pend_q <= 1'b0;
    end
  end

  assign req_o = level_mode_i ? ~sync_i : pend_q;
endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl import irq_trig_pkg::*; #(
  parameter int unsigned         ADDR_W     = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]   BASE_ADDR  = DEF_BASE_ADDR,
  parameter int unsigned         N_LINES    = DEF_LINES,
  parameter logic [N_LINES-1:0]  FIXED_MASK = DEF_FIXED,
  parameter int unsigned         SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  io_addr_i,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  input  logic [REG_W-1:0]   io_wdata_i,
  output logic [REG_W-1:0]   io_rdata_o,
  input  logic [N_LINES-1:0] irq_raw_i,
  input  logic [N_LINES-1:0] irq_ack_i,
  output logic [N_LINES-1:0] irq_req_o
);
  logic [N_LINES-1:0] mode_q, mode_chg, irq_sync;

  trig_mode_regs #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .N_LINES(N_LINES), .FIXED_MASK(FIXED_MASK)
  ) u_regs (
    .clk_i, .rst_ni, .io_addr_i, .io_wr_i, .io_rd_i, .io_wdata_i, .io_rdata_o,
    .mode_o(mode_q), .mode_chg_o(mode_chg)
  );

  irq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_raw_i), .q_o(irq_sync)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    irq_line_cond u_cond (
      .clk_i, .rst_ni,
      .sync_i(irq_sync[i]), .level_mode_i(mode_q[i]), .mode_chg_i(mode_chg[i]),
      .ack_i(irq_ack_i[i]), .req_o(irq_req_o[i])
    );
  end
endmodule

// File: rtl/irq_trig_ctrl_chk.sv
module irq_trig_ctrl_chk import irq_trig_pkg::*; #(
  parameter int unsigned         ADDR_W     = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]   BASE_ADDR  = DEF_BASE_ADDR,
  parameter int unsigned         N_LINES    = DEF_LINES,
  parameter logic [N_LINES-1:0]  FIXED_MASK = DEF_FIXED
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               io_rd_i,
  input logic [ADDR_W-1:0]  io_addr_i,
  input logic [REG_W-1:0]   io_rdata_o,
  input logic [N_LINES-1:0] irq_raw_i,
  input logic [N_LINES-1:0] irq_ack_i,
  input logic [N_LINES-1:0] irq_req_o,
  input logic [N_LINES-1:0] mode_q
);
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  assert_rdata_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == '0);

  assert_fixed_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == BASE_ADDR) |-> (io_rdata_o & FIXED_MASK[REG_W-1:0]) == '0);

  assert_fixed_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == BASE_ADDR + ADDR_W'(1)) |->
      (io_rdata_o & FIXED_MASK[2*REG_W-1:REG_W]) == '0);

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    assert_level_track_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 3'd3 && mode_q[g]) |-> irq_req_o[g] == !$past(irq_raw_i[g], 2));

    assert_edge_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst == 3'd4 && !mode_q[g] && !$past(mode_q[g]) && $rose(irq_req_o[g])) |->
        ($past(irq_raw_i[g], 3) && !$past(irq_raw_i[g], 4)));

    assert_edge_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 3'd2 && !mode_q[g] && !$past(mode_q[g]) && $fell(irq_req_o[g])) |->
        $past(irq_ack_i[g]));
  end
endmodule

bind irq_trig_ctrl irq_trig_ctrl_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .N_LINES(N_LINES), .FIXED_MASK(FIXED_MASK)
) u_chk (
  .clk_i, .rst_ni, .io_rd_i, .io_addr_i, .io_rdata_o,
  .irq_raw_i, .irq_ack_i, .irq_req_o, .mode_q
);

// File: tb/irq_trig_ctrl_tb.sv
module irq_trig_ctrl_tb;
  localparam logic [15:0] BASE = 16'h04D0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic [15:0] raw = '0, ack = '0, req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  irq_trig_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .irq_raw_i(raw), .irq_ack_i(ack), .irq_req_o(req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    io_read(BASE, d);        chk("R1 lo reg", {8'h0, d}, 16'h0);
    io_read(BASE + 16'd1, d); chk("R1 hi reg", {8'h0, d}, 16'h0);
    chk("R1 req idle", req, 16'h0);
    chk("R2 rdata no read", {8'h0, io_rdata}, 16'h0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    io_write(BASE, 8'h50);
    io_write(BASE + 16'd1, 8'h84);
    io_read(BASE, d);        chk("R2 lo readback", {8'h0, d}, 16'h0050);
    io_read(BASE + 16'd1, d); chk("R2 hi readback", {8'h0, d}, 16'h0084);
    io_write(BASE + 16'd2, 8'hFF);
    io_write(BASE - 16'd1, 8'hFF);
    io_read(BASE, d);        chk("R2 stray write lo", {8'h0, d}, 16'h0050);
    io_read(BASE + 16'd1, d); chk("R2 stray write hi", {8'h0, d}, 16'h0084);
    io_read(BASE + 16'd2, d); chk("R2 stray read", {8'h0, d}, 16'h0);
    io_write(BASE, 8'h00);
    io_write(BASE + 16'd1, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    io_write(BASE, 8'hFF);
    io_write(BASE + 16'd1, 8'hFF);
    io_read(BASE, d);        chk("R3 lo mask", {8'h0, d}, 16'h00F8);
    io_read(BASE + 16'd1, d); chk("R3 hi mask", {8'h0, d}, 16'h00DE);
    wait_edges(3);
    // level lines with raw low read as active; fixed lines stay edge
    chk("R8 fixed lines edge", req, 16'hDEF8);
    raw = 16'h2001; // rise on lines 0 and 13
    wait_edges(3);
    chk("R8 fixed lines latch", req & 16'h2107, 16'h2001);
    raw = 16'h0000;
    wait_edges(3);
    chk("R8 fixed hold", req & 16'h2107, 16'h2001);
    @(negedge clk); ack = 16'h2001;
    @(negedge clk); ack = 16'h0;
    chk("R5 ack fixed", req & 16'h2107, 16'h0);
    io_write(BASE, 8'h00);
    io_write(BASE + 16'd1, 8'h00);
  endtask

  task automatic t_edge;
    @(negedge clk); raw[6] = 1'b1;
    wait_edges(1);
    @(posedge clk); @(negedge clk);
    chk("R4 before latency", req, 16'h0);
    wait_edges(1);
    chk("R4 at latency", req, 16'h0040);
    raw[6] = 1'b0;
    wait_edges(4);
    chk("R4 hold after input low", req, 16'h0040);
    ack[6] = 1'b1;
    @(negedge clk); ack[6] = 1'b0;
    chk("R5 ack clears", req, 16'h0);
    wait_edges(2);
    chk("R5 stays clear", req, 16'h0);
  endtask

  task automatic t_ack_collide;
    @(negedge clk); raw[10] = 1'b1;
    wait_edges(3);
    chk("R4 line 10 set", req, 16'h0400);
    raw[10] = 1'b0;
    wait_edges(3);
    raw[10] = 1'b1;
    // rise detected before 3rd edge; ack lands on the same edge
    wait_edges(1);
    @(posedge clk);
    @(negedge clk); ack[10] = 1'b1;
    @(negedge clk); ack[10] = 1'b0;
    chk("R5 edge wins over ack", req, 16'h0400);
    ack[10] = 1'b1;
    @(negedge clk); ack[10] = 1'b0;
    chk("R5 later ack clears", req, 16'h0);
    raw[10] = 1'b0;
    wait_edges(3);
  endtask

  task automatic t_level;
    raw[4] = 1'b1;
    wait_edges(3);
    io_write(BASE, 8'h10);
    chk("R6 level high input", req, 16'h0);
    raw[4] = 1'b0;
    wait_edges(1);
    chk("R6 one edge old", req, 16'h0);
    wait_edges(1);
    chk("R6 low input asserts", req, 16'h0010);
    raw[4] = 1'b1;
    wait_edges(2);
    chk("R6 no latch", req, 16'h0);
    io_write(BASE, 8'h00);
    chk("R7 back to edge no stale", req, 16'h0);
    raw[4] = 1'b0;
    wait_edges(3);
  endtask

  task automatic t_mode_clear;
    @(negedge clk); raw[9] = 1'b1;
    wait_edges(3);
    chk("R4 line 9 pending", req, 16'h0200);
    io_write(BASE + 16'd1, 8'h02);
    chk("R6 line 9 level high in", req, 16'h0);
    io_write(BASE + 16'd1, 8'h00);
    wait_edges(2);
    chk("R7 pending cleared", req, 16'h0);
    raw[9] = 1'b0;
    wait_edges(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_ack_collide();
    t_level();
    t_mode_clear();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule